// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout

This block catches software that has lost control. Once started, it counts main-clock periods towards a timeout picked from a fixed set of power-of-two lengths. Software must issue a run command again before each timeout ends. Every run command clears the timeout count and starts it again. If the count reaches its end first, the block sends one request. A mode bit chosen when the watchdog is started decides whether that request is a system reset or a non-maskable interrupt.

The timeout is built from two counters. A free-running prescaler runs on the main clock and divides it down into ticks. A timeout counter of `CNT_W` bits counts those ticks. A run command clears the timeout counter but leaves the prescaler alone. As a result, the first tick after a restart can come early, and the real timeout can be up to one tick period (a fraction 2^-CNT_W) shorter than the nominal value. Both counters hold still while the chip is in stop mode and while the CPU runs from the subsystem clock. They keep counting in halt mode.

Top module: `wdt_top`

## Requirements
- R1: After reset, run_o, wdt_en_o and act_rst_o are 0, sel_o is 000, and neither request output is asserted.
- R2: Register writes use wr_addr_i. With wr_addr_i=0 (mode), wr_data_i[2] is the run command, wr_data_i[1] is the watchdog enable and wr_data_i[0] is the action select. With wr_addr_i=1, wr_data_i[2:0] is the interval select. Writing run=1 starts the watchdog, and every later run=1 write restarts the count. Once started, the watchdog cannot be stopped by writing run=0.
- R3: Let T = 2^(BASE_EXP+code) for codes 000 to 110, and T = 2^(BASE_EXP+8) for code 111, in main-clock cycles. Count the rising edges after the edge that captures the restart. The request appears at edge k with T - T/2^CNT_W + 1 <= k <= T. Defaults are BASE_EXP=12 and CNT_W=8.
- R4: On expiry, action select 1 pulses rst_req_o and action select 0 pulses nmi_req_o. The two requests are never asserted together.
- R5: While the watchdog enable is 0, no request is raised, even when run is set.
- R6: Each request lasts one cycle and is raised once per expiry. No further request is raised until run is written again.
- R7: halt_i has no effect on counting.
- R8: While stop_i is 1, both counters freeze. Cycles spent in stop do not count toward the timeout.
- R9: While sub_clk_i is 1, both counters freeze in the same way.
- R10: Once run is 1, writes no longer change the enable and action bits. They keep their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: mode register, 1: interval select |
| wr_data_i | input | 3 | Write data |
| halt_i | input | 1 | CPU halt mode indicator |
| stop_i | input | 1 | Stop mode indicator, main oscillator off |
| sub_clk_i | input | 1 | CPU running from the subsystem clock |
| rst_req_o | output | 1 | System reset request pulse |
| nmi_req_o | output | 1 | Non-maskable interrupt request pulse |
| run_o | output | 1 | Watchdog started |
| wdt_en_o | output | 1 | Detection enable bit |
| act_rst_o | output | 1 | Action select: 1 reset, 0 NMI |
| sel_o | output | 3 | Current interval select |

## Verification
The bench builds the block with BASE_EXP=6 and CNT_W=3. This shrinks every timeout by a factor of 64 while keeping the same code-to-length structure, including the extra doubling at code 111. Even the longest interval then expires in about 16k cycles, so the bench can measure it directly. With only eight ticks per timeout, the early-tick window left by the uncleared prescaler is one eighth of the timeout. The bench checks both edges of that window, and a timeout off by one power of two falls outside it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HALT = 2'd1,
    PM_STOP = 2'd2
  } pm_e;

  localparam logic WR_MODE = 1'b0;
  localparam logic WR_SEL  = 1'b1;

  localparam int unsigned TOP_STEP = 8;  // code 111 skips one doubling

  function automatic int unsigned tick_exp(input logic [2:0] code,
                                           input int unsigned base_exp,
                                           input int unsigned cnt_w);
    int unsigned off;
    off = (code == 3'b111) ? TOP_STEP : int'(code);
    return base_exp - cnt_w + off;
  endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned PRE_W = 12,
  localparam int unsigned EXP_W = $clog2(PRE_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (en_i) pre_q <= pre_q + 1'b1;
  end

  // tick on the increment that carries out of bit exp_i-1
  always_comb begin
    mask   = ~({PRE_W{1'b1}} << exp_i);
    tick_o = en_i && ((pre_q & mask) == mask);
  end

endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic active_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             step;

  assign step     = active_i && tick_i && !done_q && !restart_i;
  assign expire_o = step && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (step) begin
      if (cnt_q == CNT_MAX) done_q <= 1'b1;
      else                  cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [2:0] wr_data_i,
  output logic       run_o,
  output logic       en_o,
  output logic       act_o,
  output logic [2:0] sel_o,
  output logic       restart_o
);

  logic wr_mode, wr_sel;

  assign wr_mode   = wr_en_i && (wr_addr_i == WR_MODE);
  assign wr_sel    = wr_en_i && (wr_addr_i == WR_SEL);
  assign restart_o = wr_mode && wr_data_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      en_o  <= 1'b0;
      act_o <= 1'b0;
      sel_o <= 3'b000;
    end else begin
      if (wr_sel) sel_o <= wr_data_i;
      if (wr_mode) begin
        // run doubles as the lock for enable/action
        if (!run_o) begin
          en_o  <= wr_data_i[1];
          act_o <= wr_data_i[0];
        end
        if (wr_data_i[2]) run_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 12,
  parameter int unsigned CNT_W    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [2:0] wr_data_i,
  input  logic       halt_i,
  input  logic       stop_i,
  input  logic       sub_clk_i,
  output logic       rst_req_o,
  output logic       nmi_req_o,
  output logic       run_o,
  output logic       wdt_en_o,
  output logic       act_rst_o,
  output logic [2:0] sel_o
);

  localparam int unsigned PRE_W = BASE_EXP - CNT_W + TOP_STEP;
  localparam int unsigned EXP_W = $clog2(PRE_W + 1);

  pm_e              pm;
  logic             cnt_en;
  logic             restart;
  logic             tick;
  logic             expire;
  logic [EXP_W-1:0] exp_sel;

  always_comb begin
    if (stop_i)      pm = PM_STOP;
    else if (halt_i) pm = PM_HALT;
    else             pm = PM_RUN;
  end

  assign cnt_en  = (pm != PM_STOP) && !sub_clk_i;
  assign exp_sel = EXP_W'(tick_exp(sel_o, BASE_EXP, CNT_W));

  wdt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .run_o     (run_o),
    .en_o      (wdt_en_o),
    .act_o     (act_rst_o),
    .sel_o     (sel_o),
    .restart_o (restart)
  );

  wdt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en),
    .exp_i  (exp_sel),
    .tick_o (tick)
  );

  wdt_timeout #(.CNT_W(CNT_W)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .active_i  (run_o && wdt_en_o),
    .tick_i    (tick),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
      nmi_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire && act_rst_o;
      nmi_req_o <= expire && !act_rst_o;
    end
  end

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_i,
  input logic sub_clk_i,
  input logic rst_req_o,
  input logic nmi_req_o,
  input logic run_o,
  input logic wdt_en_o,
  input logic act_rst_o
);

  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_req_o, nmi_req_o})); // R4

  AST_RST_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> act_rst_o); // R4

  AST_NMI_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |-> !act_rst_o); // R4

  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o || nmi_req_o) |-> (run_o && wdt_en_o)); // R5

  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R6

  AST_NMI_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |=> !nmi_req_o); // R6

  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !(rst_req_o || nmi_req_o)); // R8

  AST_SUB_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_clk_i |=> !(rst_req_o || nmi_req_o)); // R9

  AST_MODE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> ($stable(wdt_en_o) && $stable(act_rst_o))); // R10

  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_o) |-> run_o); // R2

endmodule

bind wdt_top wdt_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stop_i    (stop_i),
  .sub_clk_i (sub_clk_i),
  .rst_req_o (rst_req_o),
  .nmi_req_o (nmi_req_o),
  .run_o     (run_o),
  .wdt_en_o  (wdt_en_o),
  .act_rst_o (act_rst_o)
);

// File: tb/wdt_top_bench.sv
module wdt_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int B = 6;
  localparam int C = 3;
  localparam int WATCHDOG_CYC = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [2:0] wr_data = 3'b000;
  logic       halt = 1'b0;
  logic       stop = 1'b0;
  logic       sub_clk = 1'b0;
  logic       rst_req, nmi_req, run, wdt_en, act_rst;
  logic [2:0] sel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  wdt_top #(.BASE_EXP(B), .CNT_W(C)) u_wdt_top (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .halt_i    (halt),
    .stop_i    (stop),
    .sub_clk_i (sub_clk),
    .rst_req_o (rst_req),
    .nmi_req_o (nmi_req),
    .run_o     (run),
    .wdt_en_o  (wdt_en),
    .act_rst_o (act_rst),
    .sel_o     (sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ex(input int code);
    return (code == 7) ? (B - C + 8) : (B - C + code);
  endfunction
  function automatic int lo_of(input int code);
    return ((1 << C) - 1) * (1 << ex(code)) + 1;
  endfunction
  function automatic int hi_of(input int code);
    return (1 << C) * (1 << ex(code));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; halt = 1'b0; stop = 1'b0; sub_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [2:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_req(input int limit, output int n, output logic r, output logic m);
    n = 0; r = 1'b0; m = 1'b0;
    while (n < limit && !r && !m) begin
      @(posedge clk); @(negedge clk);
      n++; r = rst_req; m = nmi_req;
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req || nmi_req) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic expect_expiry(input int code, input bit want_rst, input string req);
    int n; logic r, m;
    wait_req(hi_of(code) + 4, n, r, m);
    chk(n >= lo_of(code) && n <= hi_of(code), req, n, hi_of(code));
    chk(r == want_rst && m == !want_rst, {req, " kind"}, {r, m}, {want_rst, !want_rst});
    @(posedge clk); @(negedge clk);
    chk(!rst_req && !nmi_req, "R6 width", {rst_req, nmi_req}, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(run == 0 && wdt_en == 0 && act_rst == 0, "R1 mode", {run, wdt_en, act_rst}, 0);
    chk(sel == 3'b000, "R1 sel", sel, 0);
    chk(!rst_req && !nmi_req, "R1 req", {rst_req, nmi_req}, 0);
  endtask

  task automatic t_codes();
    for (int code = 0; code < 8; code++) begin
      if (code == 2 || code == 4) continue;
      do_reset();
      wr(1'b1, 3'(code));
      chk(sel == 3'(code), "R2 sel write", sel, code);
      wr(1'b0, 3'b111);
      chk(run && wdt_en && act_rst, "R2 start", {run, wdt_en, act_rst}, 7);
      expect_expiry(code, 1'b1, "R3 window");
    end
  endtask

  task automatic t_restart();
    do_reset();
    wr(1'b1, 3'd1);
    wr(1'b0, 3'b110);
    for (int k = 0; k < 5; k++) begin
      quiet(lo_of(1) / 2, "R2 kept alive");
      wr(1'b0, 3'b100);
    end
    expect_expiry(1, 1'b0, "R2 restart window");
  endtask

  task automatic t_nmi_once();
    do_reset();
    wr(1'b0, 3'b110);
    expect_expiry(0, 1'b0, "R4 nmi");
    quiet(3 * hi_of(0), "R6 once per expiry");
    wr(1'b0, 3'b100);
    expect_expiry(0, 1'b0, "R6 rearm");
  endtask

  task automatic t_disabled();
    do_reset();
    wr(1'b0, 3'b101);
    chk(run == 1 && wdt_en == 0, "R5 state", {run, wdt_en}, 2);
    quiet(3 * hi_of(0), "R5 disabled");
  endtask

  task automatic t_halt();
    do_reset();
    halt = 1'b1;
    wr(1'b0, 3'b111);
    expect_expiry(0, 1'b1, "R7 halt");
    halt = 1'b0;
  endtask

  task automatic t_freeze(input bit use_stop, input string req);
    do_reset();
    wr(1'b1, 3'd1);
    if (use_stop) stop = 1'b1; else sub_clk = 1'b1;
    wr(1'b0, 3'b111);
    quiet(3 * hi_of(1), req);
    stop = 1'b0; sub_clk = 1'b0;
    expect_expiry(1, 1'b1, req);
  endtask

  task automatic t_lock();
    do_reset();
    wr(1'b0, 3'b111);
    wr(1'b0, 3'b000);
    chk(run == 1, "R2 no stop", run, 1);
    chk(wdt_en == 1 && act_rst == 1, "R10 lock", {wdt_en, act_rst}, 3);
    wr(1'b0, 3'b100);
    chk(wdt_en == 1 && act_rst == 1, "R10 lock restart", {wdt_en, act_rst}, 3);
    expect_expiry(0, 1'b1, "R10 action kept");
  endtask

  initial begin
    t_reset_state();
    t_codes();
    t_restart();
    t_nmi_once();
    t_disabled();
    t_halt();
    t_freeze(1'b1, "R8 stop");
    t_freeze(1'b0, "R9 subclk");
    t_lock();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYC, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule